// File: doc/BRIEF.md
# Fuzzy cluster centre estimator

This block keeps running, membership-weighted statistics for a two-cluster fuzzy partition of a pixel stream. It updates them once per frame and delivers the two cluster centres used to grade the next frame. Each active pixel arrives with a single stored membership value for the first cluster. The membership for the second cluster is the 8-bit complement of that value. With the fuzzy exponent fixed at 2, each cluster's weight is its membership squared.

For each cluster, a weight sum and a weight-times-pixel sum are accumulated over the frame. A frame-end pulse, taken from vertical blanking, starts a short serial division that turns each pair of sums into a new centre. The centres change only when that division finishes and are held unchanged for the whole active frame. On the first frame after start-up there is no stored membership yet, so the pixel value itself is used as the cluster-1 membership. Until the first update has completed, the centres sit at their start-up values 0x00 and 0xFF. A valid flag reports when real estimates have replaced them.

Top module: `fcm_centre_est`

## Requirements
- R1: After reset, centre1_o is 0x00, centre2_o is 0xFF and centres_valid_o is 0.
- R2: While first_i is 1, the cluster-1 membership of a valid pixel is taken from pix_i, and memb_i is ignored.
- R3: The cluster-2 membership of a pixel is 255 minus its cluster-1 membership.
- R4: At a frame update, each centre becomes floor(sum(w*p) / sum(w)) over the valid pixels p of the frame. Here w is the square of that pixel's membership to the cluster.
- R5: The centres take their new values exactly 11 clock edges after the edge that samples frame_end_i high. They do not change at any other time.
- R6: If a cluster's weight sum for the frame is zero, that cluster's centre keeps its previous value.
- R7: centres_valid_o becomes 1 when the first update completes, whether or not a centre changed, and stays 1 until reset.
- R8: The sums restart from zero after each frame-end capture, so each update depends only on the pixels since the previous frame end.
- R9: pix_i, memb_i and first_i have no effect in cycles where valid_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_i | input | 8 | Pixel value |
| memb_i | input | 8 | Stored membership of the pixel to cluster 1 |
| valid_i | input | 1 | Pixel and membership are valid this cycle |
| first_i | input | 1 | First frame: use the pixel as the cluster-1 membership |
| frame_end_i | input | 1 | One-cycle pulse at the start of vertical blanking |
| centre1_o | output | 8 | Centre of cluster 1 |
| centre2_o | output | 8 | Centre of cluster 2 |
| centres_valid_o | output | 1 | At least one update has completed |

## Verification
The assertions take for granted that valid_i stays low from the cycle after the frame-end pulse until the division has finished, 11 edges later. They also assume that a second frame-end pulse does not arrive during that window. Under these conditions, the centres stay steady whenever pixels are flowing, and the weight sums never decrease within a frame. The stimulus ends every frame with a frame-end pulse, then keeps valid_i low for at least 13 cycles before the next frame starts. Any idle cycles inserted inside a frame carry deliberately misleading pixel and membership values, so that R9 is exercised.

// File: rtl/fcm_centre_est.sv
module fcm_centre_est #(
  parameter int PIX_W = 8,
  parameter int DEN_W = 32,
  parameter int NUM_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] memb_i,
  input  logic             valid_i,
  input  logic             first_i,
  input  logic             frame_end_i,
  output logic [PIX_W-1:0] centre1_o,
  output logic [PIX_W-1:0] centre2_o,
  output logic             centres_valid_o
);
  localparam int W_W   = 2 * PIX_W;
  localparam int P_W   = 3 * PIX_W;
  localparam int CNT_W = $clog2(PIX_W + 1);
  localparam int X_W   = NUM_W + 1;
  localparam logic [PIX_W-1:0] MAXV = {PIX_W{1'b1}};

  logic [PIX_W-1:0] m1, m2;
  assign m1 = first_i ? pix_i : memb_i;
  assign m2 = MAXV - m1;

  logic [W_W-1:0]   w_r [2];
  logic [PIX_W-1:0] p_r;
  logic             v_r;
  logic [2:0]       fe_r;
  logic             cap;
  assign cap = fe_r[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_r    <= 1'b0;
      p_r    <= '0;
      w_r[0] <= '0;
      w_r[1] <= '0;
      fe_r   <= '0;
    end else begin
      v_r  <= valid_i;
      fe_r <= {fe_r[1:0], frame_end_i};
      if (valid_i) begin
        w_r[0] <= W_W'(m1) * W_W'(m1);
        w_r[1] <= W_W'(m2) * W_W'(m2);
        p_r    <= pix_i;
      end
    end
  end

  logic [DEN_W-1:0] den_acc [2];
  logic [DEN_W-1:0] den_q   [2];
  logic [NUM_W-1:0] num_acc [2];
  logic [P_W-1:0]   wp      [2];

  always_comb begin
    for (int j = 0; j < 2; j++)
      wp[j] = P_W'(w_r[j]) * P_W'(p_r);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < 2; j++) begin
        den_acc[j] <= '0;
        num_acc[j] <= '0;
        den_q[j]   <= '0;
      end
    end else begin
      for (int j = 0; j < 2; j++) begin
        den_q[j] <= den_acc[j];
        if (cap) begin
          den_acc[j] <= '0;
          num_acc[j] <= '0;
        end else if (v_r) begin
          den_acc[j] <= den_acc[j] + DEN_W'(w_r[j]);
          num_acc[j] <= num_acc[j] + NUM_W'(wp[j]);
        end
      end
    end
  end

  logic             busy;
  logic [CNT_W-1:0] cnt, k;
  logic [NUM_W-1:0] rem    [2];
  logic [NUM_W-1:0] rem_nx [2];
  logic [DEN_W-1:0] dv     [2];
  logic [PIX_W-1:0] q      [2];
  logic [PIX_W-1:0] q_nx   [2];
  logic [X_W-1:0]   sh     [2];
  logic [PIX_W-1:0] cen    [2];

  assign k = cnt - CNT_W'(1);

  always_comb begin
    for (int j = 0; j < 2; j++) begin
      sh[j] = X_W'(dv[j]) << k;
      if ({1'b0, rem[j]} >= sh[j]) begin
        rem_nx[j] = NUM_W'({1'b0, rem[j]} - sh[j]);
        q_nx[j]   = q[j] | (PIX_W'(1) << k);
      end else begin
        rem_nx[j] = rem[j];
        q_nx[j]   = q[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy            <= 1'b0;
      cnt             <= '0;
      centres_valid_o <= 1'b0;
      cen[0]          <= '0;
      cen[1]          <= MAXV;
      for (int j = 0; j < 2; j++) begin
        rem[j] <= '0;
        dv[j]  <= '0;
        q[j]   <= '0;
      end
    end else if (cap) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(PIX_W);
      for (int j = 0; j < 2; j++) begin
        rem[j] <= num_acc[j];
        dv[j]  <= den_q[j];
        q[j]   <= '0;
      end
    end else if (busy) begin
      cnt <= k;
      for (int j = 0; j < 2; j++) begin
        rem[j] <= rem_nx[j];
        q[j]   <= q_nx[j];
      end
      if (cnt == CNT_W'(1)) begin
        busy            <= 1'b0;
        centres_valid_o <= 1'b1;
        for (int j = 0; j < 2; j++)
          if (dv[j] != '0) cen[j] <= q_nx[j];
      end
    end
  end

  assign centre1_o = cen[0];
  assign centre2_o = cen[1];

  // R5: centres are steady while pixels flow
  a_r5_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> ($stable(centre1_o) && $stable(centre2_o)));

  // R5: a centre only moves at the end of a division
  a_r5_change_after_div: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(centre1_o) && $stable(centre2_o)) |-> $past(busy));

  // R7: valid flag rises only when a division ends, and never drops
  a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(centres_valid_o) |-> $past(busy));
  a_r7_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    centres_valid_o |=> centres_valid_o);

  // R4: weight sums do not wrap within a frame
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (v_r && !cap) |=> (den_acc[0] >= $past(den_acc[0]) && den_acc[1] >= $past(den_acc[1])));

  // R8: sums are empty right after a capture
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (den_acc[0] == '0 && den_acc[1] == '0));
endmodule

// File: tb/fcm_centre_est_bench.sv
`timescale 1ns/1ps
module fcm_centre_est_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pix = '0, memb = '0;
  logic valid = 1'b0, first = 1'b0, fe = 1'b0;
  logic [7:0] c1, c2;
  logic cv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  longint dsum [2];
  longint nsum [2];
  int exp_c [2];
  bit exp_v;

  always #2 clk = ~clk;

  fcm_centre_est u_fcm_centre_est (
    .clk(clk), .rst_n(rst_n), .pix_i(pix), .memb_i(memb), .valid_i(valid),
    .first_i(first), .frame_end_i(fe), .centre1_o(c1), .centre2_o(c2),
    .centres_valid_o(cv)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic px(input int p, input int m, input bit f);
    int mm;
    @(negedge clk);
    pix = p[7:0]; memb = m[7:0]; first = f; valid = 1'b1;
    mm = f ? p : m;
    dsum[0] += longint'(mm * mm);
    dsum[1] += longint'((255 - mm) * (255 - mm));
    nsum[0] += longint'(mm * mm) * p;
    nsum[1] += longint'((255 - mm) * (255 - mm)) * p;
  endtask

  task automatic junk(input int p, input int m);
    @(negedge clk);
    valid = 1'b0; pix = p[7:0]; memb = m[7:0]; first = ~first;
  endtask

  task automatic end_frame(input string tag);
    @(negedge clk);
    valid = 1'b0; fe = 1'b1;
    @(negedge clk);
    fe = 1'b0;
    repeat (5) @(negedge clk);
    check({tag, " R5 centre1 held"}, int'(c1), exp_c[0]);
    check({tag, " R5 centre2 held"}, int'(c2), exp_c[1]);
    for (int j = 0; j < 2; j++) begin
      if (dsum[j] != 0) exp_c[j] = int'(nsum[j] / dsum[j]);
      dsum[j] = 0;
      nsum[j] = 0;
    end
    exp_v = 1'b1;
    repeat (8) @(negedge clk);
    check({tag, " centre1"}, int'(c1), exp_c[0]);
    check({tag, " centre2"}, int'(c2), exp_c[1]);
    check({tag, " R7 valid"}, int'(cv), int'(exp_v));
  endtask

  initial begin
    for (int j = 0; j < 2; j++) begin dsum[j] = 0; nsum[j] = 0; end
    exp_c[0] = 0; exp_c[1] = 255; exp_v = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 centre1 reset", int'(c1), 0);
    check("R1 centre2 reset", int'(c2), 255);
    check("R1 valid reset", int'(cv), 0);

    // empty first frame: no weight, centres kept, flag set
    end_frame("R6 R7 empty");
    repeat (3) @(negedge clk);

    // first frame: pixel is the membership, memb_i is misleading
    for (int i = 0; i < 64; i++) px(i * 4, 255 - i * 4, 1'b1);
    end_frame("R2 first");
    repeat (3) @(negedge clk);

    // membership sweep with junk idle cycles
    for (int i = 0; i < 256; i++) begin
      if (i % 3 == 0) junk(255, 0);
      px((i * 37 + 11) & 255, i, 1'b0);
    end
    end_frame("R3 R4 R9 sweep");
    repeat (3) @(negedge clk);

    // cluster 1 gets no weight
    for (int i = 0; i < 50; i++) px(i * 3, 0, 1'b0);
    end_frame("R6 R8 zero1");
    repeat (3) @(negedge clk);

    // cluster 2 gets no weight
    for (int i = 0; i < 30; i++) px(200 - i, 255, 1'b0);
    end_frame("R6 R8 zero2");
    repeat (3) @(negedge clk);

    // mixed pattern
    for (int i = 0; i < 41; i++) begin
      if (i % 5 == 2) junk(i * 7, 255 - i);
      px(255 - i * 5, (i * i) & 255, 1'b0);
    end
    end_frame("R4 R8 R9 mixed");

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule